// File: doc/BRIEF.md
# Filter Memory Debug Access Port

This block lets a host inspect and patch the two working memories of a filter accelerator: the delay-line sample memory and the coefficient memory. The host reaches it over a simple register bus with four registers: control, address, write-data and read-data. The block also holds the two single-port RAMs and a narrow datapath-side port. The filter datapath uses that port whenever debug access is not granted.

Debug access is granted only while the enable, hold and memory-access control bits are all set. The address register then points into one of the memories. One address bit picks the memory and the low bits give the word offset. A write to the write-data register stores a word at that location. A read of the read-data register returns the word from that location one cycle later. With auto-increment on, the offset steps after every data access and wraps inside the selected memory, so it never crosses into the other memory. While access is not granted the block stays passive: data-register accesses do nothing and the datapath owns both RAMs.

Top module: `filt_mem_dbg`

## Requirements
- R1: After reset, reads of the control register (select 0) and the address register (select 1) return zero.
- R2: The control register keeps written bits 3:0 (bit 0 enable, bit 1 hold, bit 2 memory access, bit 3 auto-increment) and reads its other bits as zero.
- R3: The address register keeps written bits 11:0 and reads bits 31:12 as zero; bits 10:0 are the word offset.
- R4: Debug memory access is granted only while control bits 0, 1 and 2 are all 1.
- R5: Address bit 11 selects the coefficient memory when 1 and the delay-line memory when 0. The two memories are separate, 2048 words of 32 bits each.
- R6: While access is granted, a bus write to the write-data register (select 2) stores the written word at the addressed location.
- R7: A bus read returns data with rvalid_o on the cycle after the request. For the read-data register (select 3) the data is the word at the address that was current before that access's increment.
- R8: With control bit 3 set, every granted read-data or write-data access advances the offset by one. With bit 3 clear, the address does not change.
- R9: Auto-increment from offset 2047 wraps to offset 0 with bit 11 unchanged, so no location of the other memory is touched.
- R10: While access is not granted, write-data writes leave both memories unchanged, read-data reads return zero, and the address register does not move.
- R11: While access is not granted, the datapath port reads and writes the memory picked by dp_bank_i, with read data on the next cycle. While access is granted, datapath requests have no effect on the memories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register bus request |
| we_i | input | 1 | Register bus write (1) or read (0) |
| reg_sel_i | input | 2 | Register select: 0 control, 1 address, 2 write-data, 3 read-data |
| wdata_i | input | 32 | Register bus write data |
| rdata_o | output | 32 | Register bus read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| dp_en_i | input | 1 | Datapath memory request |
| dp_we_i | input | 1 | Datapath write (1) or read (0) |
| dp_bank_i | input | 1 | Datapath memory select: 1 coefficient, 0 delay line |
| dp_off_i | input | 11 | Datapath word offset |
| dp_wdata_i | input | 32 | Datapath write data |
| dp_rdata_o | output | 32 | Datapath read data, one cycle after the read |

## Verification
On every cycle the assertions check several local rules. A read answers on the next cycle. A granted auto-increment moves the offset by exactly one and never changes the memory-select bit. An access that is not granted leaves the address alone and reads back zero. The datapath cannot touch a RAM while debug owns it. What was actually stored where can only be shown by the bench scenarios: write-then-read in both memories, the wrap at offset 2047 without disturbing the other memory, and writes rejected while disabled that leave old contents in place.

// File: rtl/filt_mem_dbg_pkg.sv
package filt_mem_dbg_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_ADDR  = 2'd1,
    REG_WDATA = 2'd2,
    REG_RDATA = 2'd3
  } reg_sel_e;

  // bit 0 en, bit 1 hold, bit 2 mem_acc, bit 3 auto_inc
  typedef struct packed {
    logic auto_inc;
    logic mem_acc;
    logic hold;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    RS_ZERO = 2'd0,
    RS_REG  = 2'd1,
    RS_RAM  = 2'd2
  } rd_src_e;

endpackage

// File: rtl/filt_mem_dbg_regs.sv
module filt_mem_dbg_regs
  import filt_mem_dbg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 11,
  localparam int unsigned AW    = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              grant_o,
  output logic              acc_o,
  output logic              acc_we_o,
  output logic              bank_o,
  output logic [OFF_W-1:0]  off_o,
  output rd_src_e           rd_src_o,
  output logic              rd_bank_o,
  output logic [DATA_W-1:0] rd_reg_o,
  output logic              rvalid_o
);

  ctrl_t            ctrl_q;
  logic [AW-1:0]    addr_q, addr_d;
  logic             data_rd, data_wr, addr_wr, ctrl_wr;
  logic [OFF_W-1:0] off_inc;
  rd_src_e          rd_src_q;
  logic             rd_bank_q, rvalid_q;
  logic [DATA_W-1:0] rd_reg_q;

  assign grant_o  = ctrl_q.en & ctrl_q.hold & ctrl_q.mem_acc;
  assign data_rd  = req_i & ~we_i & (reg_sel_i == REG_RDATA);
  assign data_wr  = req_i &  we_i & (reg_sel_i == REG_WDATA);
  assign addr_wr  = req_i &  we_i & (reg_sel_i == REG_ADDR);
  assign ctrl_wr  = req_i &  we_i & (reg_sel_i == REG_CTRL);
  assign acc_o    = grant_o & (data_rd | data_wr);
  assign acc_we_o = data_wr;
  assign bank_o   = addr_q[OFF_W];
  assign off_o    = addr_q[OFF_W-1:0];
  assign off_inc  = addr_q[OFF_W-1:0] + OFF_W'(1);

  // Bank bit is held; offset wraps inside the selected memory
  always_comb begin
    addr_d = addr_q;
    if (addr_wr)                     addr_d = wdata_i[AW-1:0];
    else if (acc_o && ctrl_q.auto_inc) addr_d = {addr_q[OFF_W], off_inc};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      rd_src_q  <= RS_ZERO;
      rd_bank_q <= 1'b0;
      rd_reg_q  <= '0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i && !we_i) begin
        rd_bank_q <= addr_q[OFF_W];
        rd_reg_q  <= '0;
        rd_src_q  <= RS_ZERO;
        unique case (reg_sel_e'(reg_sel_i))
          REG_CTRL: begin
            rd_src_q <= RS_REG;
            rd_reg_q <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
          end
          REG_ADDR: begin
            rd_src_q <= RS_REG;
            rd_reg_q <= {{(DATA_W-AW){1'b0}}, addr_q};
          end
          REG_RDATA: rd_src_q <= grant_o ? RS_RAM : RS_ZERO;
          default:   rd_src_q <= RS_ZERO;
        endcase
      end
    end
  end

  assign rd_src_o  = rd_src_q;
  assign rd_bank_o = rd_bank_q;
  assign rd_reg_o  = rd_reg_q;
  assign rvalid_o  = rvalid_q;

  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && ctrl_q.auto_inc && (data_rd || data_wr))
      |=> (addr_q[OFF_W-1:0] == OFF_W'($past(addr_q[OFF_W-1:0]) + OFF_W'(1)))) // R8
    else $error("offset did not step by one");

  AST_BANK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && (data_rd || data_wr)) |=> (addr_q[OFF_W] == $past(addr_q[OFF_W]))) // R9
    else $error("auto-increment changed memory select");

  AST_ADDR_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_o && (data_rd || data_wr)) |=> $stable(addr_q)) // R10
    else $error("address moved without grant");

  AST_NO_INC_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.auto_inc && (data_rd || data_wr)) |=> $stable(addr_q)) // R8
    else $error("address moved with auto-increment off");

endmodule

// File: rtl/filt_mem_dbg_ram.sv
module filt_mem_dbg_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      rdata_q     <= mem[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/filt_mem_dbg_arb.sv
module filt_mem_dbg_arb #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              dbg_en_i,
  input  logic              dbg_we_i,
  input  logic [OFF_W-1:0]  dbg_addr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic              dp_en_i,
  input  logic              dp_we_i,
  input  logic [OFF_W-1:0]  dp_addr_i,
  input  logic [DATA_W-1:0] dp_wdata_i,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [OFF_W-1:0]  ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o
);

  // Debug owns the RAM for as long as the grant holds
  always_comb begin
    if (grant_i) begin
      ram_en_o    = dbg_en_i;
      ram_we_o    = dbg_en_i & dbg_we_i;
      ram_addr_o  = dbg_addr_i;
      ram_wdata_o = dbg_wdata_i;
    end else begin
      ram_en_o    = dp_en_i;
      ram_we_o    = dp_en_i & dp_we_i;
      ram_addr_o  = dp_addr_i;
      ram_wdata_o = dp_wdata_i;
    end
  end

  AST_DP_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !dbg_en_i) |-> !ram_en_o) // R11
    else $error("datapath reached RAM during debug grant");

  AST_DBG_PASSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_i && !dp_en_i) |-> !ram_en_o) // R10
    else $error("RAM enabled without grant or datapath request");

endmodule

// File: rtl/filt_mem_dbg.sv
module filt_mem_dbg
  import filt_mem_dbg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 11,
  localparam int unsigned DEPTH = 1 << OFF_W,
  localparam int unsigned NBANK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              dp_en_i,
  input  logic              dp_we_i,
  input  logic              dp_bank_i,
  input  logic [OFF_W-1:0]  dp_off_i,
  input  logic [DATA_W-1:0] dp_wdata_i,
  output logic [DATA_W-1:0] dp_rdata_o
);

  logic              grant, acc, acc_we, bank;
  logic [OFF_W-1:0]  off;
  rd_src_e           rd_src;
  logic              rd_bank, rvalid;
  logic [DATA_W-1:0] rd_reg;
  logic [DATA_W-1:0] ram_rdata [NBANK];
  logic              dp_bank_q;

  filt_mem_dbg_regs #(.DATA_W(DATA_W), .OFF_W(OFF_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .reg_sel_i (reg_sel_i),
    .wdata_i   (wdata_i),
    .grant_o   (grant),
    .acc_o     (acc),
    .acc_we_o  (acc_we),
    .bank_o    (bank),
    .off_o     (off),
    .rd_src_o  (rd_src),
    .rd_bank_o (rd_bank),
    .rd_reg_o  (rd_reg),
    .rvalid_o  (rvalid)
  );

  // bank 0 delay line, bank 1 coefficients
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              ram_en, ram_we;
    logic [OFF_W-1:0]  ram_addr;
    logic [DATA_W-1:0] ram_wdata;

    filt_mem_dbg_arb #(.DATA_W(DATA_W), .OFF_W(OFF_W)) arb_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .grant_i     (grant),
      .dbg_en_i    (acc && (bank == b[0])),
      .dbg_we_i    (acc_we),
      .dbg_addr_i  (off),
      .dbg_wdata_i (wdata_i),
      .dp_en_i     (dp_en_i && (dp_bank_i == b[0])),
      .dp_we_i     (dp_we_i),
      .dp_addr_i   (dp_off_i),
      .dp_wdata_i  (dp_wdata_i),
      .ram_en_o    (ram_en),
      .ram_we_o    (ram_we),
      .ram_addr_o  (ram_addr),
      .ram_wdata_o (ram_wdata)
    );

    filt_mem_dbg_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ram_i (
      .clk_i   (clk_i),
      .en_i    (ram_en),
      .we_i    (ram_we),
      .addr_i  (ram_addr),
      .wdata_i (ram_wdata),
      .rdata_o (ram_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               dp_bank_q <= 1'b0;
    else if (dp_en_i && !dp_we_i && !grant)    dp_bank_q <= dp_bank_i;
  end

  assign dp_rdata_o = ram_rdata[dp_bank_q];
  assign rvalid_o   = rvalid;

  always_comb begin
    rdata_o = '0;
    if (rvalid) begin
      unique case (rd_src)
        RS_REG:  rdata_o = rd_reg;
        RS_RAM:  rdata_o = ram_rdata[rd_bank];
        default: rdata_o = '0;
      endcase
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o) // R7
    else $error("read not answered on next cycle");

  AST_RD_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (reg_sel_i == REG_RDATA) && !grant) |=> (rdata_o == '0)) // R10
    else $error("read-data returned nonzero without grant");

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o) // R7
    else $error("rvalid without a read");

endmodule

// File: tb/filt_mem_dbg_tb_top.sv
`timescale 1ns/1ps
module filt_mem_dbg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        dp_en = 1'b0, dp_we = 1'b0, dp_bank = 1'b0;
  logic [10:0] dp_off = '0;
  logic [31:0] dp_wdata = '0;
  logic [31:0] dp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;  // 250 MHz

  filt_mem_dbg dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .req_i (req), .we_i (we), .reg_sel_i (sel), .wdata_i (wdata),
    .rdata_o (rdata), .rvalid_o (rvalid),
    .dp_en_i (dp_en), .dp_we_i (dp_we), .dp_bank_i (dp_bank),
    .dp_off_i (dp_off), .dp_wdata_i (dp_wdata), .dp_rdata_o (dp_rdata)
  );

  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_WD = 2'd2, S_RD = 2'd3;
  localparam logic [31:0] C_ON = 32'h7, C_ON_INC = 32'hF;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [31:0] d);
    req = 1'b1; we = 1'b1; sel = s; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; sel = s;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic dp_write(input logic b, input logic [10:0] o, input logic [31:0] d);
    dp_en = 1'b1; dp_we = 1'b1; dp_bank = b; dp_off = o; dp_wdata = d;
    @(posedge clk); #1;
    dp_en = 1'b0; dp_we = 1'b0;
  endtask

  task automatic dp_read(input logic b, input logic [10:0] o, input logic [31:0] exp, input string tag);
    dp_en = 1'b1; dp_we = 1'b0; dp_bank = b; dp_off = o;
    @(posedge clk); #1;
    dp_en = 1'b0;
    check(dp_rdata === exp, tag, dp_rdata, exp);
  endtask

  // Monitor: compares each read response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected rvalid", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    bus_rd(S_CTRL, 32'h0, "R1 ctrl after reset");
    bus_rd(S_ADDR, 32'h0, "R1 addr after reset");

    // R2 control field width
    bus_wr(S_CTRL, 32'hFFFF_FFFF);
    bus_rd(S_CTRL, 32'hF, "R2 ctrl readback");
    bus_wr(S_CTRL, C_ON);

    // R3 address field width
    bus_wr(S_ADDR, 32'hABCD_E805);
    bus_rd(S_ADDR, 32'h805, "R3 addr high bits zero");

    // R5 R6 both memories, same offset
    bus_wr(S_ADDR, 32'h010);
    bus_wr(S_WD, 32'h1111_0010);
    bus_rd(S_ADDR, 32'h010, "R8 no increment when bit3 clear");
    bus_wr(S_ADDR, 32'h810);
    bus_wr(S_WD, 32'h2222_0810);
    bus_wr(S_ADDR, 32'h010);
    bus_rd(S_RD, 32'h1111_0010, "R6 delay-line readback");
    bus_wr(S_ADDR, 32'h810);
    bus_rd(S_RD, 32'h2222_0810, "R5 coefficient readback");

    // R8 auto-increment burst
    bus_wr(S_CTRL, C_ON_INC);
    bus_wr(S_ADDR, 32'h020);
    for (int i = 0; i < 4; i++) bus_wr(S_WD, 32'hC0DE_0000 + i);
    bus_rd(S_ADDR, 32'h024, "R8 address after write burst");
    bus_wr(S_ADDR, 32'h020);
    for (int i = 0; i < 4; i++) bus_rd(S_RD, 32'hC0DE_0000 + i, "R7 pre-increment read burst");
    bus_rd(S_ADDR, 32'h024, "R8 address after read burst");

    // R9 wrap in delay line
    bus_wr(S_ADDR, 32'h7FF);
    bus_wr(S_WD, 32'hAAAA_07FF);
    bus_wr(S_WD, 32'hBBBB_0000);
    bus_rd(S_ADDR, 32'h001, "R9 delay-line wrap address");
    bus_wr(S_ADDR, 32'h7FF);
    bus_rd(S_RD, 32'hAAAA_07FF, "R9 delay-line last word");
    bus_rd(S_RD, 32'hBBBB_0000, "R9 delay-line wrapped word");

    // R9 wrap in coefficients
    bus_wr(S_ADDR, 32'hFFF);
    bus_wr(S_WD, 32'hCCCC_0FFF);
    bus_wr(S_WD, 32'hEEEE_0800);
    bus_rd(S_ADDR, 32'h801, "R9 coefficient wrap address");
    bus_wr(S_ADDR, 32'hFFF);
    bus_rd(S_RD, 32'hCCCC_0FFF, "R9 coefficient last word");
    bus_rd(S_RD, 32'hEEEE_0800, "R9 coefficient wrapped word");
    bus_wr(S_ADDR, 32'h000);
    bus_rd(S_RD, 32'hBBBB_0000, "R9 delay line untouched by coefficient wrap");

    // R4 R10 access without hold
    bus_wr(S_CTRL, 32'hD);
    bus_wr(S_ADDR, 32'h010);
    bus_wr(S_WD, 32'hDEAD_BEEF);
    bus_rd(S_RD, 32'h0, "R10 read-data zero when disabled");
    bus_rd(S_ADDR, 32'h010, "R10 address unchanged when disabled");
    bus_wr(S_CTRL, 32'hE);
    bus_wr(S_WD, 32'hDEAD_0001);
    bus_rd(S_RD, 32'h0, "R4 no access without enable");
    bus_wr(S_CTRL, 32'hB);
    bus_wr(S_WD, 32'hDEAD_0002);
    bus_rd(S_RD, 32'h0, "R4 no access without memory bit");
    bus_wr(S_CTRL, C_ON);
    bus_rd(S_RD, 32'h1111_0010, "R10 rejected writes left memory intact");

    // R11 datapath ownership
    bus_wr(S_CTRL, 32'h0);
    dp_read(1'b0, 11'h010, 32'h1111_0010, "R11 datapath sees debug write");
    dp_write(1'b0, 11'h030, 32'h3030_0000);
    dp_write(1'b1, 11'h030, 32'h3131_0000);
    dp_read(1'b0, 11'h030, 32'h3030_0000, "R11 datapath delay-line readback");
    dp_read(1'b1, 11'h030, 32'h3131_0000, "R11 datapath coefficient readback");
    bus_wr(S_CTRL, C_ON);
    dp_write(1'b0, 11'h030, 32'hBAD0_BAD0);
    bus_wr(S_ADDR, 32'h030);
    bus_rd(S_RD, 32'h3030_0000, "R11 datapath write blocked during grant");
    bus_wr(S_ADDR, 32'h830);
    bus_rd(S_RD, 32'h3131_0000, "R11 coefficient intact during grant");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) check(1'b0, "R7 missing responses", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule